// File: doc/BRIEF.md
# Frame-Stepped Alpha Fade Controller

This block supplies the alpha value used to blend a graphics layer over video. Inside a rectangular window placed relative to the reference sync pulses, it outputs a running alpha that starts from a programmable initial value. Every few frames it steps that value up or down by a programmable coefficient, so the layer fades in or out. Everywhere else, and whenever the function is off, it outputs a fully opaque alpha.

Frames are counted on rising edges of the reference vertical sync. All settings are sampled only on that edge, so the alpha in the window never changes partway through a frame. A start request reloads the running value at the next frame boundary. A done flag reports that a fade has reached the end of the range.

Top module: `fade_alpha_gen`

## Requirements
- R1: While reset is held, and after its release until the first frame boundary, `alpha_o` is 0xFF and `done_o` is 0.
- R2: `alpha_o` is 0xFF for any pixel where `de_i` is low, where the pixel lies outside the window, or where the function was disabled at the last vsync rise. `alpha_o` is registered, one clock after the inputs it depends on.
- R3: A pixel's column is the number of clocks since the clock in which `hsync_i` was first seen high. Columns `win_hstart_i+10` through `win_hstart_i+10+win_width_i-1` are inside the window.
- R4: A line's number is the number of `hsync_i` rises since the last `vsync_i` rise. Lines `win_vstart_i+1` through `win_vstart_i+win_height_i` are inside the window.
- R5: A one-clock pulse on `fade_start_i` is remembered until the next `vsync_i` rise. At that rise the running alpha is loaded from `alpha_init_i`, the frame counter is cleared and `done_o` is cleared. No step is taken on that frame.
- R6: With `frame_rate_i` = N, a step is taken on every (N+1)-th `vsync_i` rise after the load. N = 0 steps every frame and N = 0xFF steps every 256 frames.
- R7: With `fade_mode_i` = 2'b01, a step adds `alpha_step_i` to the running alpha and saturates at 0xFF.
- R8: With `fade_mode_i` = 2'b10, a step subtracts `alpha_step_i` from the running alpha and saturates at 0x00.
- R9: With `fade_mode_i` = 2'b00 or 2'b11, a step leaves the running alpha unchanged.
- R10: `done_o` goes high on the frame boundary where a step produces 0xFF (adding) or 0x00 (subtracting). It stays high until a start load clears it, and it changes only on a vsync rise.
- R11: Changes to the initial value, mode, coefficient or window that are made during a frame take effect only from the next `vsync_i` rise. The running alpha changes only on such a rise.
- R12: When `fade_en_i` is low at a vsync rise, no step is taken, the frame counter holds, and the next frame shows 0xFF everywhere. When it is re-enabled, stepping resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Reference horizontal sync, active high |
| vsync_i | input | 1 | Reference vertical sync, active high |
| de_i | input | 1 | Data enable for the current pixel |
| fade_en_i | input | 1 | Enables the fade function |
| fade_start_i | input | 1 | Start request, reloads the running alpha at the next frame |
| fade_mode_i | input | 2 | 00/11 hold, 01 add, 10 subtract |
| alpha_init_i | input | AW | Initial alpha value |
| alpha_step_i | input | AW | Coefficient applied at each step |
| frame_rate_i | input | RW | Step interval minus one, in frames |
| win_hstart_i | input | HW | Window horizontal start (offset by 10 columns) |
| win_width_i | input | HW | Window width in pixels |
| win_vstart_i | input | VW | Window vertical start (offset by 1 line) |
| win_height_i | input | VW | Window height in lines |
| alpha_o | output | AW | Alpha for the current pixel |
| done_o | output | 1 | Fade has reached the end of the range |

## Verification
The assertions assume that `de_i` is low in the clocks where an `hsync_i` or `vsync_i` rise is seen. They also assume that each line is longer than the window's last column, so the column count left over from the previous line never falls inside the window. The stimulus builds every line from 64 clocks. Both syncs sit in the first nine of them, while the data enable starts only at column 12, and the window ends well before column 64. Start pulses are placed two clocks before the vsync rise or in the middle of a frame, so they never coincide with it.

// File: rtl/fade_pkg.sv
package fade_pkg;

  // Step operation selected by the two-bit mode field
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLD2 = 2'b11
  } step_mode_e;

  // Fixed position offsets of the window relative to the sync edges
  localparam int unsigned HOFS = 10;
  localparam int unsigned VOFS = 1;

endpackage

// File: rtl/fade_edge.sv
module fade_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/fade_span.sv
// Range test: hit when start+OFS <= pos < start+OFS+len
module fade_span #(
  parameter int unsigned W   = 12,
  parameter int unsigned OFS = 10
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] len_i,
  output logic         hit_o
);

  localparam int unsigned EW = W + 2;

  logic [EW-1:0] lo, hi, pos_x;

  assign lo    = EW'(start_i) + EW'(OFS);
  assign hi    = lo + EW'(len_i);
  assign pos_x = EW'(pos_i);
  assign hit_o = (pos_x >= lo) && (pos_x < hi);

endmodule

// File: rtl/fade_raster.sv
// Column/line counters and the frame-latched window, producing in_win
module fade_raster
  import fade_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hs_rise_i,
  input  logic          vs_rise_i,
  input  logic [HW-1:0] hstart_i,
  input  logic [HW-1:0] width_i,
  input  logic [VW-1:0] vstart_i,
  input  logic [VW-1:0] height_i,
  output logic          in_win_o
);

  localparam logic [HW-1:0] HMAX = '1;
  localparam logic [VW-1:0] VMAX = '1;

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [VW-1:0] vcnt_q, vcnt_d;
  logic [HW-1:0] hst_q, wid_q;
  logic [VW-1:0] vst_q, hgt_q;
  logic          win_ld;
  logic          h_hit, v_hit;

  // Next-state for the position counters
  always_comb begin
    hcnt_d = hcnt_q;
    if (hs_rise_i)           hcnt_d = HW'(1);
    else if (hcnt_q != HMAX) hcnt_d = hcnt_q + 1'b1;

    vcnt_d = vcnt_q;
    if (vs_rise_i)                           vcnt_d = '0;
    else if (hs_rise_i && (vcnt_q != VMAX))  vcnt_d = vcnt_q + 1'b1;
  end

  assign win_ld = vs_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      vcnt_q <= vcnt_d;
    end
  end

  // Window geometry, captured once per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hst_q <= '0;
      wid_q <= '0;
      vst_q <= '0;
      hgt_q <= '0;
    end else if (win_ld) begin
      hst_q <= hstart_i;
      wid_q <= width_i;
      vst_q <= vstart_i;
      hgt_q <= height_i;
    end
  end

  fade_span #(.W(HW), .OFS(HOFS)) u_hspan (
    .pos_i   (hcnt_q),
    .start_i (hst_q),
    .len_i   (wid_q),
    .hit_o   (h_hit)
  );

  fade_span #(.W(VW), .OFS(VOFS)) u_vspan (
    .pos_i   (vcnt_q),
    .start_i (vst_q),
    .len_i   (hgt_q),
    .hit_o   (v_hit)
  );

  assign in_win_o = h_hit & v_hit;

endmodule

// File: rtl/fade_ramp.sv
// Frame counter, running alpha with saturating steps, done flag
module fade_ramp
  import fade_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vs_rise_i,
  input  logic          start_i,
  input  logic          enable_i,
  input  step_mode_e    mode_i,
  input  logic [AW-1:0] init_i,
  input  logic [AW-1:0] coef_i,
  input  logic [RW-1:0] rate_i,
  output logic [AW-1:0] run_o,
  output logic          done_o,
  output logic          en_o
);

  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] BOT = '0;

  logic [AW-1:0] run_q, run_d;
  logic [RW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          en_q, en_d;
  logic          pend_q, pend_d;
  logic [AW:0]   sum, dif;
  logic [AW-1:0] up_val, dn_val;
  logic          frame_ld;
  logic          reload;

  assign sum    = {1'b0, run_q} + {1'b0, coef_i};
  assign dif    = {1'b0, run_q} - {1'b0, coef_i};
  assign up_val = sum[AW] ? TOP : sum[AW-1:0];
  assign dn_val = dif[AW] ? BOT : dif[AW-1:0];
  assign reload = pend_q | start_i;
  assign frame_ld = vs_rise_i;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    en_d   = enable_i;
    pend_d = vs_rise_i ? 1'b0 : reload;

    if (reload) begin
      run_d  = init_i;
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (enable_i) begin
      if (cnt_q >= rate_i) begin
        cnt_d = '0;
        case (mode_i)
          STEP_UP: begin
            run_d  = up_val;
            done_d = done_q | (up_val == TOP);
          end
          STEP_DOWN: begin
            run_d  = dn_val;
            done_d = done_q | (dn_val == BOT);
          end
          default: begin
            run_d = run_q;
          end
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // Pending start flag updates every clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  // Frame state updates only at the vsync rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= TOP;
      cnt_q  <= '0;
      done_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (frame_ld) begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      en_q   <= en_d;
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;
  assign en_o   = en_q;

endmodule

// File: rtl/fade_alpha_gen.sv
module fade_alpha_gen
  import fade_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11,
  parameter int unsigned AW = 8,
  parameter int unsigned RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic          de_i,
  input  logic          fade_en_i,
  input  logic          fade_start_i,
  input  logic [1:0]    fade_mode_i,
  input  logic [AW-1:0] alpha_init_i,
  input  logic [AW-1:0] alpha_step_i,
  input  logic [RW-1:0] frame_rate_i,
  input  logic [HW-1:0] win_hstart_i,
  input  logic [HW-1:0] win_width_i,
  input  logic [VW-1:0] win_vstart_i,
  input  logic [VW-1:0] win_height_i,
  output logic [AW-1:0] alpha_o,
  output logic          done_o
);

  localparam int unsigned NSYNC  = 2;
  localparam logic [AW-1:0] OPAQUE = '1;

  logic [1:0]       rst_sync_q;
  logic             rst_n_sync;
  logic [NSYNC-1:0] sync_in, sync_rise;
  logic             hs_rise, vs_rise;
  logic             in_win;
  logic [AW-1:0]    run_alpha;
  logic             en_sh;
  logic [AW-1:0]    alpha_d, alpha_q;
  step_mode_e       mode;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  assign sync_in = {vsync_i, hsync_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_edge
    fade_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_n_sync),
      .sig_i  (sync_in[g]),
      .rise_o (sync_rise[g])
    );
  end

  assign hs_rise = sync_rise[0];
  assign vs_rise = sync_rise[1];
  assign mode    = step_mode_e'(fade_mode_i);

  fade_raster #(.HW(HW), .VW(VW)) u_raster (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .hs_rise_i (hs_rise),
    .vs_rise_i (vs_rise),
    .hstart_i  (win_hstart_i),
    .width_i   (win_width_i),
    .vstart_i  (win_vstart_i),
    .height_i  (win_height_i),
    .in_win_o  (in_win)
  );

  fade_ramp #(.AW(AW), .RW(RW)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .vs_rise_i (vs_rise),
    .start_i   (fade_start_i),
    .enable_i  (fade_en_i),
    .mode_i    (mode),
    .init_i    (alpha_init_i),
    .coef_i    (alpha_step_i),
    .rate_i    (frame_rate_i),
    .run_o     (run_alpha),
    .done_o    (done_o),
    .en_o      (en_sh)
  );

  always_comb begin
    alpha_d = OPAQUE;
    if (en_sh && de_i && in_win) alpha_d = run_alpha;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) alpha_q <= OPAQUE;
    else             alpha_q <= alpha_d;
  end

  assign alpha_o = alpha_q;

endmodule

// File: rtl/fade_alpha_chk.sv
module fade_alpha_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          de,
  input logic [AW-1:0] alpha,
  input logic          done,
  input logic          vs_edge,
  input logic [AW-1:0] run_alpha,
  input logic          en_sh
);

  // R2
  opaque_no_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> (alpha == {AW{1'b1}}));

  // R12
  opaque_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_sh |=> (alpha == {AW{1'b1}}));

  // R11
  run_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(run_alpha));

  // R10
  done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(done));

  // R10
  done_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ((run_alpha == {AW{1'b1}}) || (run_alpha == {AW{1'b0}})));

endmodule

bind fade_alpha_gen fade_alpha_chk #(.AW(AW)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n_sync),
  .de        (de_i),
  .alpha     (alpha_o),
  .done      (done_o),
  .vs_edge   (vs_rise),
  .run_alpha (run_alpha),
  .en_sh     (en_sh)
);

// File: tb/sim_fade_alpha_gen.sv
module sim_fade_alpha_gen;

  localparam int LINE_LEN = 64;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, hs, vs, de, en, start;
  logic [1:0]  mode;
  logic [7:0]  init, coef, rate;
  logic [11:0] hst, wid;
  logic [10:0] vst, hgt;
  logic [7:0]  alpha;
  logic        done;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    cmp_en = 0;
  bit    start_req = 0;
  string tag = "R1";
  logic [7:0] cap [0:15][0:63];

  fade_alpha_gen u0 (
    .clk_i (clk), .rst_ni (rst_n), .hsync_i (hs), .vsync_i (vs), .de_i (de),
    .fade_en_i (en), .fade_start_i (start), .fade_mode_i (mode),
    .alpha_init_i (init), .alpha_step_i (coef), .frame_rate_i (rate),
    .win_hstart_i (hst), .win_width_i (wid), .win_vstart_i (vst), .win_height_i (hgt),
    .alpha_o (alpha), .done_o (done)
  );

  // Behavioural reference: integers counting clocks and lines since the sync rises
  int m_col, m_line, m_run, m_cnt, m_hs, m_wd, m_vs, m_ht, exp_alpha;
  bit m_hp, m_vp, m_pend, m_done, m_en, m_hr, m_vr, m_in, exp_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_col = 1 << 20; m_line = 0; m_run = 255; m_cnt = 0;
      m_hs = 0; m_wd = 0; m_vs = 0; m_ht = 0;
      m_hp = 0; m_vp = 0; m_pend = 0; m_done = 0; m_en = 0;
      exp_alpha = 255; exp_done = 0;
    end else begin
      m_hr = hs && !m_hp;
      m_vr = vs && !m_vp;
      m_hp = hs;
      m_vp = vs;
      if (m_hr) begin m_col = 0; m_line = m_line + 1; end
      else m_col = m_col + 1;
      m_in = (m_col >= m_hs + 10) && (m_col < m_hs + 10 + m_wd) &&
             (m_line >= m_vs + 1) && (m_line < m_vs + 1 + m_ht);
      exp_alpha = (m_en && de && m_in) ? m_run : 255;
      if (start) m_pend = 1;
      if (m_vr) begin
        m_line = 0;
        m_en = en;
        m_hs = hst; m_wd = wid; m_vs = vst; m_ht = hgt;
        if (m_pend) begin
          m_run = init; m_cnt = 0; m_done = 0;
        end else if (en) begin
          if (m_cnt >= rate) begin
            m_cnt = 0;
            if (mode == 2'b01) begin
              m_run = (m_run + coef > 255) ? 255 : m_run + coef;
              if (m_run == 255) m_done = 1;
            end else if (mode == 2'b10) begin
              m_run = (m_run < coef) ? 0 : m_run - coef;
              if (m_run == 0) m_done = 1;
            end
          end else begin
            m_cnt = m_cnt + 1;
          end
        end
        m_pend = 0;
      end
      exp_done = m_done;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Compare with the reference on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk({tag, " alpha_o"}, int'(alpha), exp_alpha);
      chk({tag, " done_o"}, int'(done), int'(exp_done));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      finish_sim();
    end
  end

  // One frame of 64-clock lines; syncs in columns 0..8, data enable from column 12
  task automatic run_frame(input int nlines, input bit mid);
    for (int l = 0; l < nlines; l++) begin
      for (int c = 0; c < LINE_LEN; c++) begin
        @(negedge clk);
        if (c > 0) cap[l][c-1] = alpha;
        else if (l > 0) cap[l-1][LINE_LEN-1] = alpha;
        hs = (c < 2);
        vs = (l == 0) && (c >= 4) && (c < 9);
        de = (c >= 12) && (c < 59);
        start = 1'b0;
        if (l == 0 && c == 2 && start_req) begin start = 1'b1; start_req = 0; end
        if (mid && l == 2 && c == 0) begin
          init = 8'h11; mode = 2'b01; coef = 8'h20; hst = 12'd0; start = 1'b1;
        end
      end
    end
  endtask

  initial begin
    rst_n = 0; hs = 0; vs = 0; de = 0; en = 0; start = 0;
    mode = 2'b00; init = 8'h40; coef = 8'h00; rate = 8'h00;
    hst = 12'd5; wid = 12'd20; vst = 11'd2; hgt = 11'd4;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 alpha_o", int'(alpha), 255);
    chk("R1 done_o", int'(done), 0);
    cmp_en = 1;

    // Disabled: load happens but output stays opaque
    tag = "R2 R12";
    start_req = 1;
    run_frame(12, 0);
    run_frame(12, 0);
    chk("R2 disabled window pixel", int'(cap[4][20]), 255);

    // Enabled: window edges (cols 15..34, lines 3..6)
    tag = "R3 R4 R5";
    en = 1;
    run_frame(12, 0);
    chk("R5 loaded init", int'(cap[4][20]), 8'h40);
    chk("R3 first column", int'(cap[4][15]), 8'h40);
    chk("R3 column before", int'(cap[4][14]), 255);
    chk("R3 last column", int'(cap[4][34]), 8'h40);
    chk("R3 column after", int'(cap[4][35]), 255);
    chk("R4 first line", int'(cap[3][20]), 8'h40);
    chk("R4 line above", int'(cap[2][20]), 255);
    chk("R4 last line", int'(cap[6][20]), 8'h40);
    chk("R4 line below", int'(cap[7][20]), 255);
    chk("R2 de low column", int'(cap[4][60]), 255);
    tag = "R9";
    run_frame(12, 0);
    run_frame(12, 0);
    chk("R9 hold mode 00", int'(cap[4][20]), 8'h40);

    // Add every two frames: 40,70,70,A0,A0,D0,D0,FF
    tag = "R6 R7 R10";
    mode = 2'b01; coef = 8'h30; rate = 8'h01;
    run_frame(12, 0);
    chk("R6 no step first frame", int'(cap[4][20]), 8'h40);
    run_frame(12, 0);
    chk("R6 step on second frame", int'(cap[4][20]), 8'h70);
    run_frame(12, 0);
    chk("R6 held between steps", int'(cap[4][20]), 8'h70);
    repeat (4) run_frame(12, 0);
    chk("R7 before limit", int'(cap[4][20]), 8'hD0);
    chk("R10 not done yet", int'(done), 0);
    run_frame(12, 0);
    chk("R7 saturated at FF", int'(cap[4][20]), 8'hFF);
    chk("R10 done at top", int'(done), 1);

    // Subtract every frame from C8: C8,78,28,00
    tag = "R5 R8 R10";
    init = 8'hC8; mode = 2'b10; coef = 8'h50; rate = 8'h00; start_req = 1;
    run_frame(12, 0);
    chk("R5 reload value", int'(cap[4][20]), 8'hC8);
    chk("R10 cleared by start", int'(done), 0);
    run_frame(12, 0);
    run_frame(12, 0);
    chk("R8 step down", int'(cap[4][20]), 8'h28);
    run_frame(12, 0);
    chk("R8 saturated at 00", int'(cap[4][20]), 8'h00);
    chk("R10 done at bottom", int'(done), 1);

    // Mid-frame writes wait for the next vsync
    tag = "R11";
    init = 8'h90; mode = 2'b00; start_req = 1;
    run_frame(12, 0);
    chk("R5 load 90", int'(cap[4][20]), 8'h90);
    run_frame(12, 1);
    chk("R11 old value kept", int'(cap[4][20]), 8'h90);
    chk("R11 old window kept", int'(cap[4][14]), 255);
    run_frame(12, 0);
    chk("R11 new value applied", int'(cap[4][20]), 8'h11);
    chk("R11 new window applied", int'(cap[4][12]), 8'h11);
    run_frame(12, 0);
    chk("R7 add 20", int'(cap[4][20]), 8'h31);

    // Disable freezes the ramp
    tag = "R12";
    en = 0;
    run_frame(12, 0);
    chk("R12 opaque when off", int'(cap[4][20]), 255);
    run_frame(12, 0);
    en = 1;
    run_frame(12, 0);
    chk("R12 resumed from held value", int'(cap[4][20]), 8'h51);

    tag = "R9";
    mode = 2'b11;
    run_frame(12, 0);
    run_frame(12, 0);
    chk("R9 hold mode 11", int'(cap[4][20]), 8'h51);

    // Rate FF: 256 frames per step, short two-line frames, window on line 1
    tag = "R6";
    vst = 11'd0; hgt = 11'd1; init = 8'h10; mode = 2'b01; coef = 8'h01;
    rate = 8'hFF; start_req = 1;
    run_frame(2, 0);
    repeat (255) run_frame(2, 0);
    chk("R6 no step before 256 frames", int'(cap[1][20]), 8'h10);
    run_frame(2, 0);
    chk("R6 step after 256 frames", int'(cap[1][20]), 8'h11);

    repeat (4) @(negedge clk);
    finish_sim();
  end

endmodule